// File: doc/BRIEF.md
# Majority-Vote Asynchronous Serial Receiver

This block turns an asynchronous serial stream on a single input line into received words. The line is sampled only on a strobe that pulses once for every sixteenth of a bit time, and the strobe is generated elsewhere. Three samples near the middle of each bit are combined by a two-out-of-three vote. This rejects short disturbances on the line, and a falsely detected start bit is dropped. Each frame has a start bit, 7 or 8 data bits sent least significant bit first, an optional raw extra bit and a stop bit. Completed words go into a small queue that the host side drains with a pop strobe.

A state machine in the sampler controls the frame. It has five states: IDLE, START, DATA, XBIT and STOP. IDLE to START is taken on a strobe where the line is low and the previous strobe sample was high. START to IDLE is taken when the voted start bit is 1, which is treated as a glitch. START to DATA is taken at the end of the start bit period. DATA stays in DATA until the last data bit. It then goes to XBIT if the extra bit is enabled, and to STOP otherwise. XBIT to STOP is taken at the end of the extra bit period. STOP to IDLE is taken as soon as the stop bit has been voted, on its 9th sample. The word is stored if the voted stop bit is 1, and the framing error is flagged if it is 0. The word length and extra-bit enable are captured when the start edge is seen.

The queue holds up to eight words, oldest first, and it has two modes. With the queue disabled it keeps a single word, and the newest word replaces it. A word that arrives while the enabled queue is full empties the whole queue, and that word is discarded as well. A synchronous clear input empties the queue, drops the framing-error flag and returns the state machine to IDLE.

Top module: `mvrx_receiver`

## Requirements
- R1: A frame starts only on a strobe where the line samples 0 and the previous strobe sample was 1. That strobe counts as sample 1 of the start bit.
- R2: Every bit, the start bit included, takes the majority value of its 7th, 8th and 9th samples. A voted start bit of 1 returns the state machine to IDLE, and no word is stored.
- R3: Data is received least significant bit first. With `len7_sel`=0, 8 bits are received into `rd_data[7:0]`. With `len7_sel`=1, 7 bits are received into `rd_data[6:0]` and `rd_data[7]` reads 0.
- R4: With `xbit_en`=1, one extra bit follows the data and is returned unchanged on `rd_xbit`, with no parity check. With `xbit_en`=0, `rd_xbit` of the stored word is 0.
- R5: A voted 0 in the stop-bit position sets `frame_err`, stores no word and returns the state machine to start-edge search. `frame_err` stays set, through pops as well, until a word with a correct stop bit arrives.
- R6: Only one stop bit is required. A start edge that follows the single stop bit directly is received.
- R7: The queue holds up to 8 words and presents them oldest first. `data_avail` is 1 whenever at least one word is held, and a pop removes the oldest word.
- R8: With `queue_en`=1, a word that arrives while 8 words are held, with no pop in the same cycle, empties the queue. The arriving word is discarded too.
- R9: With `queue_en`=0, only one word is held, and each new word replaces it.
- R10: While no word is held, `rd_data` and `rd_xbit` read 0.
- R11: `clr` empties the queue, clears `frame_err` and returns the state machine to IDLE on the next clock edge.
- R12: A pop while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of queue, flags and state machine |
| tick16 | input | 1 | One-cycle strobe, sixteen per bit time |
| rx_line | input | 1 | Serial data input, idle high |
| len7_sel | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| xbit_en | input | 1 | 1 receives one extra raw bit after the data |
| queue_en | input | 1 | 1 enables the 8-word queue, 0 selects single-word holding |
| pop | input | 1 | Removes the oldest held word |
| rd_data | output | 8 | Data of the oldest held word, 0 when empty |
| rd_xbit | output | 1 | Extra bit of the oldest held word, 0 when empty |
| data_avail | output | 1 | At least one word is held |
| frame_err | output | 1 | Last frame had a bad stop bit |

## Verification
The bench goes after the vote window. It inverts the 8th sample of every data bit, and a receiver that used the centre sample alone would return the complement. It sends a start pulse that reads low only through sample 7, which a receiver without the start vote would store as a word of ones. The queue is filled to exactly eight words and then sent a ninth. A queue that dropped only the newest word, or that wrapped, would still report data. The framing-error flag is checked across a pop and then cleared by a good frame, so a flag that was queued, cleared by reads or left sticky shows up. Seven-bit mode, the raw extra bit, single-word replacement, pops on an empty queue and frames with a single stop bit between them are each checked at the outputs.

// File: rtl/mvrx_pkg.sv
package mvrx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_DATA  = 3'd2,
        S_XBIT  = 3'd3,
        S_STOP  = 3'd4
    } rx_state_e;

    typedef struct packed {
        logic              xbit;
        logic [DATA_W-1:0] data;
    } rx_word_t;

endpackage

// File: rtl/mvrx_sync.sv
module mvrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) q[g] <= 1'b1;
                    else        q[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) q[g] <= 1'b1;
                    else        q[g] <= q[g-1];
                end
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/mvrx_sampler.sv
module mvrx_sampler
    import mvrx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     tick,
    input  logic     rx,
    input  logic     len7,
    input  logic     xbit_en,
    output logic     push,
    output rx_word_t push_word,
    output logic     frame_err
);
    localparam int CW   = $clog2(OVS);
    localparam int VMID = OVS / 2;
    localparam int BW   = $clog2(DATA_W + 1);
    localparam logic [CW:0] IDX_V0  = (CW+1)'(VMID - 1);
    localparam logic [CW:0] IDX_V1  = (CW+1)'(VMID);
    localparam logic [CW:0] IDX_DEC = (CW+1)'(VMID + 1);
    localparam logic [CW:0] IDX_END = (CW+1)'(OVS);

    rx_state_e         st_q, st_d;
    logic [CW-1:0]     cnt_q;
    logic [CW:0]       s_idx;
    logic              prev_q;
    logic [1:0]        v_q;
    logic [DATA_W-1:0] sr_q;
    logic [BW-1:0]     bidx_q;
    logic              len7_q, xen_q, xb_q;
    logic              at_dec, at_end, maj, last_bit;

    assign s_idx    = {1'b0, cnt_q} + (CW+1)'(1);
    assign at_dec   = tick && (s_idx == IDX_DEC);
    assign at_end   = tick && (s_idx == IDX_END);
    assign maj      = (v_q[0] & v_q[1]) | (v_q[0] & rx) | (v_q[1] & rx);
    assign last_bit = (bidx_q == (len7_q ? BW'(DATA_W - 2) : BW'(DATA_W - 1)));

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (tick) begin
            unique case (st_q)
                S_IDLE:  if (prev_q && !rx) st_d = S_START;
                S_START: begin
                    if (at_dec && maj)  st_d = S_IDLE;
                    else if (at_end)    st_d = S_DATA;
                end
                S_DATA:  if (at_end && last_bit) st_d = xen_q ? S_XBIT : S_STOP;
                S_XBIT:  if (at_end) st_d = S_STOP;
                S_STOP:  if (at_dec) st_d = S_IDLE;
                default: st_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st_q <= S_IDLE;
        else if (clr) st_q <= S_IDLE;
        else          st_q <= st_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            prev_q    <= 1'b1;
            v_q       <= 2'b00;
            sr_q      <= '0;
            bidx_q    <= '0;
            len7_q    <= 1'b0;
            xen_q     <= 1'b0;
            xb_q      <= 1'b0;
            push      <= 1'b0;
            push_word <= '0;
            frame_err <= 1'b0;
        end else if (clr) begin
            cnt_q     <= '0;
            prev_q    <= 1'b1;
            push      <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                prev_q <= rx;
                if (st_q == S_IDLE) begin
                    if (st_d == S_START) begin
                        cnt_q  <= CW'(1);
                        bidx_q <= '0;
                        len7_q <= len7;
                        xen_q  <= xbit_en;
                        xb_q   <= 1'b0;
                    end
                end else begin
                    cnt_q <= (st_d == S_IDLE) ? '0 : CW'(s_idx);
                    if (s_idx == IDX_V0) v_q[0] <= rx;
                    if (s_idx == IDX_V1) v_q[1] <= rx;
                    if (at_dec) begin
                        unique case (st_q)
                            S_DATA: sr_q <= {maj, sr_q[DATA_W-1:1]};
                            S_XBIT: xb_q <= maj;
                            S_STOP: begin
                                if (maj) begin
                                    push           <= 1'b1;
                                    push_word.xbit <= xb_q;
                                    push_word.data <= len7_q ? {1'b0, sr_q[DATA_W-1:1]} : sr_q;
                                    frame_err      <= 1'b0;
                                end else begin
                                    frame_err <= 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end
                    if (at_end && st_q == S_DATA) bidx_q <= bidx_q + BW'(1);
                end
            end
        end
    end

    // R1: entering START requires the line to have been low on the strobe
    p_start_on_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_START && $past(st_q) == S_IDLE) |-> !$past(rx));

    // R5: a word is produced only out of the stop state
    p_push_from_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> $past(st_q) == S_STOP);

    // R5: the framing error rises only out of the stop state
    p_ferr_from_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> $past(st_q) == S_STOP);

    // R2: a start vote of 1 leaves START without reaching DATA
    p_glitch_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_START && at_dec && maj && !clr) |=> st_q == S_IDLE);
endmodule

// File: rtl/mvrx_queue.sv
module mvrx_queue
    import mvrx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     queue_en,
    input  logic     push,
    input  rx_word_t push_word,
    input  logic     pop,
    output rx_word_t head,
    output logic     avail
);
    localparam int AW = $clog2(DEPTH);

    rx_word_t      slot [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr, wa;
    logic [AW:0]   count_q;
    logic          full, do_pop, overflow, we;

    assign full     = (count_q == (AW+1)'(DEPTH));
    assign do_pop   = pop && (count_q != '0);
    assign overflow = queue_en && push && full && !do_pop;
    assign we       = push && !overflow && !clr;
    assign wa       = queue_en ? wr_ptr : rd_ptr;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (we && wa == AW'(g)) slot[g] <= push_word;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count_q <= '0;
        end else if (clr || overflow) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count_q <= '0;
        end else if (push && !queue_en) begin
            wr_ptr  <= rd_ptr + AW'(1);
            count_q <= (AW+1)'(1);
        end else begin
            if (push)   wr_ptr <= wr_ptr + AW'(1);
            if (do_pop) rd_ptr <= rd_ptr + AW'(1);
            count_q <= count_q + (AW+1)'(push) - (AW+1)'(do_pop);
        end
    end

    assign avail = (count_q != '0);
    assign head  = avail ? slot[rd_ptr] : '0;

    // R7: occupancy never exceeds the depth
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= (AW+1)'(DEPTH));

    // R8: an arrival into a full queue empties it
    p_overflow_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (queue_en && push && full && !pop && !clr) |=> !avail);

    // R11: clear empties the queue
    p_clr_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !avail);

    // R12: popping an empty queue leaves it empty
    p_pop_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !avail && !push) |=> !avail);

    // R9: single-word mode never holds more than one word
    p_single_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!queue_en && push && !clr) |=> count_q == (AW+1)'(1));
endmodule

// File: rtl/mvrx_receiver.sv
module mvrx_receiver
    import mvrx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick16,
    input  logic              rx_line,
    input  logic              len7_sel,
    input  logic              xbit_en,
    input  logic              queue_en,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_xbit,
    output logic              data_avail,
    output logic              frame_err
);
    logic     rx_s;
    logic     push;
    rx_word_t push_word, head;

    mvrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_line),
        .dout  (rx_s)
    );

    mvrx_sampler #(.OVS(OVS)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .tick      (tick16),
        .rx        (rx_s),
        .len7      (len7_sel),
        .xbit_en   (xbit_en),
        .push      (push),
        .push_word (push_word),
        .frame_err (frame_err)
    );

    mvrx_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .queue_en  (queue_en),
        .push      (push),
        .push_word (push_word),
        .pop       (pop),
        .head      (head),
        .avail     (data_avail)
    );

    assign rd_data = head.data;
    assign rd_xbit = head.xbit;

    // R10: an empty receiver presents all-zero data
    p_empty_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !data_avail |-> (rd_data == '0 && !rd_xbit));
endmodule

// File: tb/test_mvrx_receiver.sv
`timescale 1ns/1ps
module test_mvrx_receiver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0, tick16 = 1'b0, rx_line = 1'b1;
    logic       len7_sel = 1'b0, xbit_en = 1'b0, queue_en = 1'b1, pop = 1'b0;
    logic [7:0] rd_data;
    logic       rd_xbit, data_avail, frame_err;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mvrx_receiver i_mvrx_receiver (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick16(tick16), .rx_line(rx_line),
        .len7_sel(len7_sel), .xbit_en(xbit_en), .queue_en(queue_en), .pop(pop),
        .rd_data(rd_data), .rd_xbit(rd_xbit), .data_avail(data_avail), .frame_err(frame_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic one_tick();
        repeat (7) @(negedge clk);
        tick16 = 1'b1;
        @(negedge clk);
        tick16 = 1'b0;
    endtask

    // one bit period; when flip is set the 8th sample is inverted
    task automatic send_bit(input logic v, input bit flip);
        for (int s = 1; s <= 16; s++) begin
            rx_line = (flip && s == 8) ? ~v : v;
            one_tick();
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input bit xen,
                              input logic xv, input logic stopv, input bit flip, input bit idle);
        send_bit(1'b0, 1'b0);
        for (int i = 0; i < nb; i++) send_bit(d[i], flip);
        if (xen) send_bit(xv, 1'b0);
        send_bit(stopv, 1'b0);
        if (idle) send_bit(1'b1, 1'b0);
        repeat (4) @(negedge clk);
    endtask

    task automatic do_pop();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 reset avail", data_avail, 0);
        chk("R10 reset data", rd_data, 0);
        chk("R10 reset xbit", rd_xbit, 0);
        chk("R5 reset ferr", frame_err, 0);
    endtask

    task automatic t_basic8();
        send_frame(8'hA5, 8, 0, 0, 1, 0, 1);
        chk("R3 basic avail", data_avail, 1);
        chk("R3 basic data", rd_data, 8'hA5);
        chk("R4 basic xbit off", rd_xbit, 0);
        do_pop();
        chk("R7 pop empties", data_avail, 0);
        chk("R10 empty data", rd_data, 0);
    endtask

    task automatic t_len7();
        len7_sel = 1'b1;
        send_frame(8'hFF, 7, 0, 0, 1, 0, 1);
        chk("R3 len7 msb zero", rd_data, 8'h7F);
        do_pop();
        len7_sel = 1'b0;
    endtask

    task automatic t_xbit();
        xbit_en = 1'b1;
        send_frame(8'h3C, 8, 1, 1, 1, 0, 1);
        chk("R4 xbit one data", rd_data, 8'h3C);
        chk("R4 xbit one", rd_xbit, 1);
        do_pop();
        send_frame(8'hC3, 8, 1, 0, 1, 0, 1);
        chk("R4 xbit zero", rd_xbit, 0);
        do_pop();
        len7_sel = 1'b1;
        send_frame(8'h55, 7, 1, 1, 1, 0, 1);
        chk("R4 len7 xbit data", rd_data, 8'h55);
        chk("R4 len7 xbit", rd_xbit, 1);
        do_pop();
        len7_sel = 1'b0;
        xbit_en = 1'b0;
    endtask

    task automatic t_vote();
        send_frame(8'h96, 8, 0, 0, 1, 1, 1);
        chk("R2 vote overrides sample 8", rd_data, 8'h96);
        do_pop();
    endtask

    task automatic t_glitch();
        for (int s = 1; s <= 16; s++) begin
            rx_line = (s <= 7) ? 1'b0 : 1'b1;
            one_tick();
        end
        for (int i = 0; i < 12; i++) send_bit(1'b1, 1'b0);
        chk("R2 glitch start stores nothing", data_avail, 0);
        send_frame(8'h11, 8, 0, 0, 1, 0, 1);
        chk("R1 frame after glitch", rd_data, 8'h11);
        do_pop();
    endtask

    task automatic t_ferr();
        send_frame(8'h42, 8, 0, 0, 0, 0, 1);
        chk("R5 ferr set", frame_err, 1);
        chk("R5 bad frame not stored", data_avail, 0);
        do_pop();
        chk("R5 ferr survives pop", frame_err, 1);
        send_frame(8'h24, 8, 0, 0, 1, 0, 1);
        chk("R5 ferr cleared by good frame", frame_err, 0);
        chk("R5 good frame data", rd_data, 8'h24);
        do_pop();
    endtask

    task automatic t_order();
        for (int i = 0; i < 8; i++) send_frame(8'(i * 17 + 1), 8, 0, 0, 1, 0, 0);
        chk("R6 back-to-back all held", data_avail, 1);
        for (int i = 0; i < 8; i++) begin
            chk("R7 oldest first", rd_data, 8'(i * 17 + 1));
            do_pop();
        end
        chk("R7 drained", data_avail, 0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 8; i++) send_frame(8'(i + 8'h40), 8, 0, 0, 1, 0, 0);
        chk("R8 full head", rd_data, 8'h40);
        send_frame(8'hEE, 8, 0, 0, 1, 0, 1);
        chk("R8 overflow empties", data_avail, 0);
        chk("R8 overflow data zero", rd_data, 0);
        send_frame(8'h5A, 8, 0, 0, 1, 0, 1);
        chk("R8 refill after overflow", rd_data, 8'h5A);
        do_pop();
        chk("R8 one word after refill", data_avail, 0);
    endtask

    task automatic t_single();
        queue_en = 1'b0;
        send_frame(8'h01, 8, 0, 0, 1, 0, 1);
        send_frame(8'h02, 8, 0, 0, 1, 0, 1);
        chk("R9 newest replaces", rd_data, 8'h02);
        do_pop();
        chk("R9 single word only", data_avail, 0);
        queue_en = 1'b1;
    endtask

    task automatic t_clr();
        send_frame(8'h81, 8, 0, 0, 1, 0, 1);
        send_frame(8'h82, 8, 0, 0, 0, 0, 1);
        chk("R11 pre-clear ferr", frame_err, 1);
        do_clr();
        chk("R11 clear empties", data_avail, 0);
        chk("R11 clear drops ferr", frame_err, 0);
    endtask

    task automatic t_pop_empty();
        do_pop();
        do_pop();
        send_frame(8'h77, 8, 0, 0, 1, 0, 1);
        chk("R12 data after empty pops", rd_data, 8'h77);
        do_pop();
        chk("R12 count intact", data_avail, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        for (int i = 0; i < 2; i++) send_bit(1'b1, 1'b0);
        t_basic8();
        t_len7();
        t_xbit();
        t_vote();
        t_glitch();
        t_ferr();
        t_order();
        t_overflow();
        t_single();
        t_clr();
        send_bit(1'b1, 1'b0);
        t_pop_empty();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule